// File: doc/BRIEF.md
# USB Interrupt Flag Register

This block keeps the eight interrupt status flags of a USB controller core. Strobes from the protocol engine set the stall, attach, token-done, start-of-frame and reset/detach flags. Two line-state duration counters set the resume and idle flags. Software clears each flag by writing a 1 to its bit. The error flag is different: software cannot write it, and it shows whether any error source that the error-enable mask lets through is active.

Clearing the token-done flag sends a one-cycle pop strobe to the transaction-status FIFO, so the next transaction record comes forward. A host-mode select changes what the stall flag and bit 0 mean. It also gates the attach flag. A per-bit enable mask picks which flags drive the single interrupt line. The timer thresholds are computed from a clock-frequency parameter.

Top module: `usb_irq_flags`

## Requirements
- R1: `rd_data[31:8]` always reads 0. The flag bits are, from bit 7 down to bit 0: stall, attach, resume, idle, token-done, SOF, error, reset/detach. After reset every flag is 0, `irq` is 0 and `fifo_pop` is 0.
- R2: For every flag except bit 1, a cycle with `wr_en`=1 and a 1 in that bit of `wr_data` clears the flag at the next clock edge. A 0 in that bit leaves the flag unchanged.
- R3: If a set event and a software clear reach the same flag in the same cycle, the flag is 1 after that edge.
- R4: After each clock edge, bit 1 equals the OR of `err_src & err_en` sampled at that edge. Writes to bit 1 have no effect.
- R5: `fifo_pop` is high for exactly the one cycle that follows an edge at which `wr_en`=1, `wr_data[3]`=1 and the token-done flag read 1. It pops even if a new token-done event sets the flag again in that same cycle.
- R6: The resume flag (bit 5) sets at the clock edge on which `line_state`=2'b10 (K) has been sampled on RES_CYC consecutive edges, where RES_CYC = ceil(RESUME_NS x CLK_KHZ / 10^6). It sets once for each K run.
- R7: The idle flag (bit 4) sets at the edge on which `line_state`=2'b01 (J) has been sampled on IDLE_CYC consecutive edges, where IDLE_CYC = ceil(IDLE_NS x CLK_KHZ / 10^6). Any change of `line_state` (2'b00 SE0, 2'b11 SE1, J or K) restarts the run.
- R8: `ev_attach` sets bit 6 only while `host_mode`=1. In device mode the strobe is ignored.
- R9: Bit 0 is set by `ev_bus_reset` when `host_mode`=0 and by `ev_detach` when `host_mode`=1. The strobe for the other mode is ignored.
- R10: Bit 7 is set by `ev_stall_rx` when `host_mode`=1 and by `ev_stall_tx` when `host_mode`=0. The strobe for the other mode is ignored.
- R11: `irq` equals the OR of the current flags ANDed with `irq_en`. It follows the flags and `irq_en` with no added delay.
- R12: `ev_token_done` sets bit 3 and `ev_sof` sets bit 2 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at CLK_KHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 selects host mode, 0 selects device mode |
| ev_stall_rx | input | 1 | Strobe: STALL handshake received (host) |
| ev_stall_tx | input | 1 | Strobe: STALL handshake sent (device) |
| ev_attach | input | 1 | Strobe: peripheral attach detected |
| ev_token_done | input | 1 | Strobe: token processing finished |
| ev_sof | input | 1 | Strobe: SOF received or SOF threshold reached |
| ev_bus_reset | input | 1 | Strobe: bus reset seen (device) |
| ev_detach | input | 1 | Strobe: peripheral detach seen (host) |
| err_src | input | ERR_W | Per-source error levels |
| err_en | input | ERR_W | Error-source enable mask |
| line_state | input | 2 | Decoded bus state: 00 SE0, 01 J, 10 K, 11 SE1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data; a 1 in a bit clears that flag |
| irq_en | input | 8 | Per-flag interrupt enable |
| rd_data | output | DATA_W | Register read value |
| irq | output | 1 | Combined interrupt request |
| fifo_pop | output | 1 | One-cycle advance strobe to the status FIFO |

## Verification
The random phase holds each line state for a random run length. The resulting K runs are just shorter than, equal to and longer than the resume threshold, which separates off-by-one errors in the resume counter from errors in restarting it. Directed idle runs of exactly IDLE_CYC edges, and of one edge fewer followed by an interruption, show whether the idle count includes the first sample and whether a line change restarts the count. The directed cases also drive a set and a clear into the same flag in one cycle, send wrong-mode strobes and attach strobes in device mode, and write to the error bit. Random write data mixed with random event strobes tells the clear-on-1 path apart from the hold-on-0 path. Toggling the mode mid-run separates the host-mode and device-mode selection of bits 0 and 7.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned B_STALL  = 7;
  localparam int unsigned B_ATTACH = 6;
  localparam int unsigned B_RESUME = 5;
  localparam int unsigned B_IDLE   = 4;
  localparam int unsigned B_TOKEN  = 3;
  localparam int unsigned B_SOF    = 2;
  localparam int unsigned B_ERR    = 1;
  localparam int unsigned B_RSTDET = 0;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  // Converts a duration in ns into a number of clock cycles, rounding up.
  // The result is never less than 1.
  function automatic longint unsigned dur_to_cycles(longint unsigned dur_ns,
                                                    longint unsigned clk_khz);
    longint unsigned c;
    c = (dur_ns * clk_khz + 64'd999_999) / 64'd1_000_000;
    if (c == 64'd0) c = 64'd1;
    return c;
  endfunction

  // Number of bits needed for a counter that reaches term.
  function automatic int unsigned cnt_bits(longint unsigned term);
    return $clog2(term + 64'd1);
  endfunction

endpackage

// File: rtl/usb_line_timer.sv
// Measures how long the line has stayed in one target state and gives a
// single pulse when the run reaches TERM consecutive samples.
module usb_line_timer #(
  parameter int unsigned TERM   = 3,
  parameter logic [1:0]  TARGET = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ls,
  input  logic       restart,
  output logic       hit
);
  localparam int unsigned CW = usb_irq_pkg::cnt_bits(longint'(TERM));
  localparam logic [CW-1:0] TERM_C  = CW'(TERM);
  localparam logic [CW-1:0] TERM_M1 = CW'(TERM - 1);
  localparam bit            TERM_IS_ONE = (TERM == 1);

  logic [CW-1:0] cnt_q;
  logic          match;

  assign match = (ls == TARGET);

  always_comb begin
    if (!match)       hit = 1'b0;
    else if (restart) hit = TERM_IS_ONE;
    else              hit = (cnt_q == TERM_M1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!match)           cnt_q <= '0;
    else if (restart)          cnt_q <= CW'(1);
    else if (cnt_q != TERM_C)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/usb_line_monitor.sv
// Detects line-state changes and runs the resume and idle duration timers.
module usb_line_monitor #(
  parameter int unsigned RES_CYC  = 120,
  parameter int unsigned IDLE_CYC = 144000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  output logic       resume_hit,
  output logic       idle_hit
);
  import usb_irq_pkg::*;

  logic [1:0] prev_q;
  logic       changed;

  assign changed = (line_state != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= LS_SE0;
    else        prev_q <= line_state;
  end

  usb_line_timer #(.TERM(RES_CYC), .TARGET(LS_K)) u_resume_tmr (
    .clk(clk), .rst_n(rst_n), .ls(line_state), .restart(changed), .hit(resume_hit)
  );

  usb_line_timer #(.TERM(IDLE_CYC), .TARGET(LS_J)) u_idle_tmr (
    .clk(clk), .rst_n(rst_n), .ls(line_state), .restart(changed), .hit(idle_hit)
  );

endmodule

// File: rtl/usb_flag_bank.sv
// Bank of flag bits: write-1-to-clear bits where a set beats a clear, plus
// one read-only level bit at position LEVEL_BIT.
module usb_flag_bank #(
  parameter int unsigned W         = 8,
  parameter int unsigned LEVEL_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         level_in,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == LEVEL_BIT) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= level_in;
      end
    end else begin : g_w1c
      always_ff @(posedge clk) begin
        if (!rst_n)          flags[i] <= 1'b0;
        else if (set_vec[i]) flags[i] <= 1'b1;
        else if (clr_vec[i]) flags[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int unsigned CLK_KHZ   = 48000,
  parameter int unsigned RESUME_NS = 2500,
  parameter int unsigned IDLE_NS   = 3000000,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              ev_stall_rx,
  input  logic              ev_stall_tx,
  input  logic              ev_attach,
  input  logic              ev_token_done,
  input  logic              ev_sof,
  input  logic              ev_bus_reset,
  input  logic              ev_detach,
  input  logic [ERR_W-1:0]  err_src,
  input  logic [ERR_W-1:0]  err_en,
  input  logic [1:0]        line_state,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              fifo_pop
);
  import usb_irq_pkg::*;

  localparam int unsigned RES_CYC  = 32'(dur_to_cycles(longint'(RESUME_NS), longint'(CLK_KHZ)));
  localparam int unsigned IDLE_CYC = 32'(dur_to_cycles(longint'(IDLE_NS), longint'(CLK_KHZ)));
  localparam int unsigned PAD_W    = DATA_W - FLAG_W;

  // Named internal events, visible to the bound checker.
  logic              resume_hit;
  logic              idle_hit;
  logic              err_active;
  logic              pop_req;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flags;
  logic              pop_q;

  usb_line_monitor #(.RES_CYC(RES_CYC), .IDLE_CYC(IDLE_CYC)) u_line (
    .clk(clk), .rst_n(rst_n), .line_state(line_state),
    .resume_hit(resume_hit), .idle_hit(idle_hit)
  );

  assign err_active = |(err_src & err_en);

  always_comb begin
    set_vec           = '0;
    set_vec[B_STALL]  = host_mode ? ev_stall_rx : ev_stall_tx;
    set_vec[B_ATTACH] = host_mode & ev_attach;
    set_vec[B_RESUME] = resume_hit;
    set_vec[B_IDLE]   = idle_hit;
    set_vec[B_TOKEN]  = ev_token_done;
    set_vec[B_SOF]    = ev_sof;
    set_vec[B_RSTDET] = host_mode ? ev_detach : ev_bus_reset;
  end

  always_comb begin
    clr_vec        = wr_en ? wr_data[FLAG_W-1:0] : '0;
    clr_vec[B_ERR] = 1'b0;
  end

  usb_flag_bank #(.W(FLAG_W), .LEVEL_BIT(B_ERR)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .level_in(err_active), .flags(flags)
  );

  // Pop when software clears a token-done flag that was set.
  assign pop_req = clr_vec[B_TOKEN] & flags[B_TOKEN];

  always_ff @(posedge clk) begin
    if (!rst_n) pop_q <= 1'b0;
    else        pop_q <= pop_req;
  end

  assign fifo_pop = pop_q;
  assign irq      = |(flags & irq_en);
  assign rd_data  = {{PAD_W{1'b0}}, flags};

endmodule

// File: rtl/usb_irq_flags_chk.sv
module usb_irq_flags_chk #(
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              ev_token_done,
  input logic              ev_sof,
  input logic [ERR_W-1:0]  err_src,
  input logic [ERR_W-1:0]  err_en,
  input logic [1:0]        line_state,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              fifo_pop,
  input logic              resume_hit,
  input logic              idle_hit
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:8] == '0);

  assert_token_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !ev_token_done) |=> !rd_data[3]);

  assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && !ev_sof) |=> rd_data[2] == $past(rd_data[2]));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> rd_data[2]);

  assert_err_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_src & err_en)) |=> rd_data[1]);

  assert_err_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(err_src & err_en)) |=> !rd_data[1]);

  assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && rd_data[3]) |=> fifo_pop);

  assert_pop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(wr_en && wr_data[3] && rd_data[3]));

  assert_resume_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_hit |=> rd_data[5]);

  assert_resume_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_hit |-> line_state == 2'b10);

  assert_idle_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> rd_data[4]);

  assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> line_state == 2'b01);

  assert_attach_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !rd_data[6]) |=> !rd_data[6]);

endmodule

bind usb_irq_flags usb_irq_flags_chk #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
  .ev_token_done(ev_token_done), .ev_sof(ev_sof),
  .err_src(err_src), .err_en(err_en), .line_state(line_state),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .fifo_pop(fifo_pop),
  .resume_hit(resume_hit), .idle_hit(idle_hit)
);

// File: tb/test_usb_irq_flags.sv
module test_usb_irq_flags;
  localparam int unsigned CLK_KHZ   = 1000;
  localparam int unsigned RESUME_NS = 2500;
  localparam int unsigned IDLE_NS   = 3000000;
  localparam int unsigned ERR_W     = 8;
  localparam int unsigned DATA_W    = 32;

  // Threshold arithmetic restated: whole microseconds times MHz, rounded up.
  function automatic int unsigned cycles_needed(int unsigned ns);
    int unsigned whole;
    whole = (ns / 1000) * (CLK_KHZ / 1000) + ((ns % 1000) * (CLK_KHZ / 1000)) / 1000;
    if (((ns % 1000) * (CLK_KHZ / 1000)) % 1000 != 0) whole = whole + 1;
    return (whole == 0) ? 1 : whole;
  endfunction

  localparam int unsigned RES_N  = 3;
  localparam int unsigned IDLE_N = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b0;
  logic ev_stall_rx = 1'b0, ev_stall_tx = 1'b0, ev_attach = 1'b0;
  logic ev_token_done = 1'b0, ev_sof = 1'b0, ev_bus_reset = 1'b0, ev_detach = 1'b0;
  logic [ERR_W-1:0]  err_src = '0, err_en = '0;
  logic [1:0]        line_state = 2'b00;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [7:0]        irq_en = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq, fifo_pop;

  always #10 clk = ~clk;

  usb_irq_flags #(.CLK_KHZ(CLK_KHZ), .RESUME_NS(RESUME_NS), .IDLE_NS(IDLE_NS),
                  .ERR_W(ERR_W), .DATA_W(DATA_W)) i_usb_irq_flags (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .ev_stall_rx(ev_stall_rx), .ev_stall_tx(ev_stall_tx), .ev_attach(ev_attach),
    .ev_token_done(ev_token_done), .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset),
    .ev_detach(ev_detach), .err_src(err_src), .err_en(err_en),
    .line_state(line_state), .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq), .fifo_pop(fifo_pop)
  );

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 1'b0;

  logic [7:0]  exp_flags = '0;
  logic        exp_pop   = 1'b0;
  logic [1:0]  m_prev    = 2'b00;
  int unsigned m_run     = 0;

  function automatic string req_of_bit(int b);
    case (b)
      7: return "R10";
      6: return "R8";
      5: return "R6";
      4: return "R7";
      3: return "R12";
      2: return "R12";
      1: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1", {8'h0, rd_data[31:8]}, 32'h0, "upper bits");
    for (int b = 0; b < 8; b++)
      check(req_of_bit(b), {31'h0, rd_data[b]}, {31'h0, exp_flags[b]},
            $sformatf("flag bit %0d (set/clear path R2/R3)", b));
    check("R11", {31'h0, irq}, {31'h0, |(exp_flags & irq_en)}, "irq");
    check("R5", {31'h0, fifo_pop}, {31'h0, exp_pop}, "fifo_pop");
  endtask

  // Advances one clock with the currently driven inputs and checks the result.
  task automatic tick();
    logic [7:0] set_m, nxt;
    logic       res_hit, idle_hit_m;
    if (line_state != m_prev) m_run = 1;
    else if (m_run < 1000000) m_run++;
    m_prev     = line_state;
    res_hit    = (line_state == 2'b10) && (m_run == RES_N);
    idle_hit_m = (line_state == 2'b01) && (m_run == IDLE_N);
    set_m    = '0;
    set_m[7] = host_mode ? ev_stall_rx : ev_stall_tx;
    set_m[6] = host_mode && ev_attach;
    set_m[5] = res_hit;
    set_m[4] = idle_hit_m;
    set_m[3] = ev_token_done;
    set_m[2] = ev_sof;
    set_m[0] = host_mode ? ev_detach : ev_bus_reset;
    for (int b = 0; b < 8; b++) begin
      if (b == 1) nxt[b] = |(err_src & err_en);
      else if (set_m[b]) nxt[b] = 1'b1;
      else if (wr_en && wr_data[b]) nxt[b] = 1'b0;
      else nxt[b] = exp_flags[b];
    end
    exp_pop = wr_en && wr_data[3] && exp_flags[3];
    exp_flags = nxt;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    {ev_stall_rx, ev_stall_tx, ev_attach, ev_token_done, ev_sof, ev_bus_reset, ev_detach} = '0;
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    if (cycles_needed(RESUME_NS) != RES_N || cycles_needed(IDLE_NS) != IDLE_N)
      $display("Note: threshold helper disagrees with constants");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", rd_data, 32'h0, "rd_data after reset");
    check("R1", {31'h0, irq}, 32'h0, "irq after reset");
    check("R1", {31'h0, fifo_pop}, 32'h0, "fifo_pop after reset");
    irq_en = 8'hFF;

    // R12 then R2: SOF set, write 0 keeps, write 1 clears
    ev_sof = 1'b1; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'hFB; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'h04; tick(); quiet();
    // R3: set and clear in one cycle
    ev_sof = 1'b1; wr_en = 1'b1; wr_data = 32'h04; tick(); quiet();
    tick();
    // R5: token done, pop with simultaneous re-set
    ev_token_done = 1'b1; tick(); quiet();
    ev_token_done = 1'b1; wr_en = 1'b1; wr_data = 32'h08; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'h08; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'h08; tick(); quiet(); // flag clear: no pop
    tick();
    // R8, R9, R10: wrong-mode strobes ignored, right-mode ones set
    host_mode = 1'b0; ev_attach = 1'b1; ev_detach = 1'b1; ev_stall_rx = 1'b1; tick(); quiet();
    ev_bus_reset = 1'b1; ev_stall_tx = 1'b1; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'hFF; tick(); quiet();
    host_mode = 1'b1; ev_bus_reset = 1'b1; ev_stall_tx = 1'b1; tick(); quiet();
    ev_attach = 1'b1; ev_detach = 1'b1; ev_stall_rx = 1'b1; tick(); quiet();
    wr_en = 1'b1; wr_data = 32'hFF; tick(); quiet();
    // R4: error level follows mask; write ignored
    err_src = 8'h10; err_en = 8'h01; tick();
    err_en = 8'h10; tick();
    wr_en = 1'b1; wr_data = 32'h02; tick(); quiet();
    err_src = 8'h00; tick();
    err_en = 8'h00;
    // R6: K for RES_N-1, break, then K for RES_N
    line_state = 2'b10; repeat (RES_N - 1) tick();
    line_state = 2'b00; tick();
    line_state = 2'b10; repeat (RES_N + 2) tick();
    // R7: J one short, interrupted, then full run
    line_state = 2'b01; repeat (IDLE_N - 1) tick();
    line_state = 2'b11; tick();
    line_state = 2'b01; repeat (IDLE_N + 2) tick();
    wr_en = 1'b1; wr_data = 32'hFF; tick(); quiet();

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      ev_stall_rx   = ($urandom % 8) == 0;
      ev_stall_tx   = ($urandom % 8) == 0;
      ev_attach     = ($urandom % 8) == 0;
      ev_token_done = ($urandom % 6) == 0;
      ev_sof        = ($urandom % 6) == 0;
      ev_bus_reset  = ($urandom % 10) == 0;
      ev_detach     = ($urandom % 10) == 0;
      wr_en         = ($urandom % 3) == 0;
      wr_data       = $urandom;
      err_src       = (($urandom % 4) == 0) ? ERR_W'($urandom) : '0;
      if (($urandom % 16) == 0) err_en = ERR_W'($urandom);
      if (($urandom % 32) == 0) irq_en = 8'($urandom);
      if (($urandom % 64) == 0) host_mode = ~host_mode;
      if (($urandom % 4) == 0) line_state = 2'($urandom);
      tick();
    end
    quiet();
    tick();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule